// File: doc/BRIEF.md
# DRAM Rank Power-State Controller

This block follows the low-power state of a single DRAM rank and decides, cycle by cycle, when the rank drops into power-down or self-refresh and when it must wake again. Its inputs are the rank's queued read and write counts, the direction the data bus will take next, strobes for commands scheduled and completed, a bank-open indication, and start and finish strobes from a refresh sequencer. Two programmable values set its timing: how long the entry conditions must hold before the rank powers down, and how long the rank must wait after waking before the next command.

Power-down is staggered. A refresh taken while the rank sits in precharge power-down does not return the rank to idle. It drops the rank one level deeper, into self-refresh. The rank leaves self-refresh only when queued work demands it. The scheduler reads the ready flag to know when it may issue a command. It reads the low-power flag to know that the rank is asleep or about to be.

Top module: `rank_pwr_ctrl`

## Requirements
- R1: The state output uses the codes idle=0, auto-refresh=1, self-refresh=2, precharge power-down=3, active=4, active power-down=5. After reset the state is idle, `cmd_ready` is 1, and `low_pwr`, `pd_enter`, `pd_exit` and `err_sticky` are 0.
- R2: From idle, an accepted `ref_start` moves the rank to auto-refresh. This has priority over `bank_open` (which moves it to active) and over power-down entry.
- R3: Active moves to idle when `bank_open` is low. Active power-down returns only to active, and does so in the cycle after a read is queued or the outstanding count is non-zero.
- R4: Precharge power-down moves to auto-refresh on `ref_start`. It moves to idle when a read is queued, the outstanding count is non-zero, or `bank_open` is high.
- R5: When `ref_done` ends a refresh, the rank enters self-refresh if the refresh was started from precharge power-down. Otherwise it returns to idle.
- R6: Self-refresh exits to idle when any read is queued, whatever the bus direction. It also exits when `bus_next_wr` is 1 and any write is queued. Queued writes with `bus_next_wr` at 0 keep the rank in self-refresh.
- R7: The rank enters power-down only from idle with no bank open, or from active with a bank open. No read may be queued, the outstanding count must be zero, and the wake delay must have expired. The change happens at the clock edge that ends the (`idle_thresh`+1)-th consecutive cycle in which these conditions hold.
- R8: The outstanding count rises by one for each `cmd_issue` and for each accepted `ref_start`. It falls by one for each `cmd_done` and for each accepted `ref_done`. While it is non-zero, power-down entry is blocked.
- R9: After a power-down or self-refresh exit, `cmd_ready` stays 0 for `exit_dly` cycles. It is 1 only in idle or active once the delay has run out.
- R10: `low_pwr` is 1 in both power-down states and in self-refresh. It is also 1 during an auto-refresh that was started from precharge power-down.
- R11: `pd_enter` pulses for one cycle on the first cycle in a power-down or self-refresh state. `pd_exit` pulses for one cycle on the first cycle in idle or active after leaving one of those states.
- R12: The following are ignored and set the sticky `err_sticky` flag: `ref_start` outside idle and precharge power-down, `ref_done` outside auto-refresh, and an outstanding count that would underflow or overflow. Only reset clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_cnt | input | CNT_W | Reads queued for this rank |
| wr_cnt | input | CNT_W | Writes queued for this rank |
| bus_next_wr | input | 1 | Next data-bus direction is write |
| cmd_issue | input | 1 | An activate, read or write was scheduled |
| cmd_done | input | 1 | A scheduled activate, read or write completed |
| bank_open | input | 1 | At least one bank of the rank is open |
| ref_start | input | 1 | Refresh sequencer begins a refresh |
| ref_done | input | 1 | Refresh sequencer finished the refresh |
| idle_thresh | input | TH_W | Extra qualifying cycles before power-down entry |
| exit_dly | input | DLY_W | Cycles to hold off commands after a wake-up |
| pwr_state | output | 3 | Current power state code |
| low_pwr | output | 1 | Rank is in, or heading into, a low-power state |
| pd_enter | output | 1 | One-cycle low-power entry strobe |
| pd_exit | output | 1 | One-cycle low-power exit strobe |
| cmd_ready | output | 1 | Rank may accept a command |
| err_sticky | output | 1 | An illegal request was seen |

## Verification
Directed sequences walk the staggered path of idle, precharge power-down, refresh and self-refresh. Holding writes queued with the bus direction first at read and then at write separates the two self-refresh exit rules. An active phase with one command in flight shows that the outstanding count alone blocks active power-down. Biased random blocks then vary the idle threshold, the exit delay, the queue counts, bank status and refresh strobes, with occasional misplaced refresh strobes. These blocks show whether the timers, the exit priority and the error flag stay consistent over interleavings that the directed cases do not reach.

// File: rtl/rank_pwr_pkg.sv
package rank_pwr_pkg;

   typedef enum logic [2:0] {
      PS_IDLE  = 3'd0,
      PS_REF   = 3'd1,
      PS_SREF  = 3'd2,
      PS_PREPD = 3'd3,
      PS_ACT   = 3'd4,
      PS_ACTPD = 3'd5
   } pwr_state_e;

   // true for states in which the rank is asleep
   function automatic logic is_asleep(input pwr_state_e s);
      return (s == PS_PREPD) || (s == PS_ACTPD) || (s == PS_SREF);
   endfunction

   // true for states in which commands may flow
   function automatic logic is_awake(input pwr_state_e s);
      return (s == PS_IDLE) || (s == PS_ACT);
   endfunction

endpackage

// File: rtl/rank_pwr_evcnt.sv
// Outstanding-event counter: commands and refreshes in flight.
module rank_pwr_evcnt #(
   parameter int OUT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc_cmd,
   input  logic             inc_ref,
   input  logic             dec_cmd,
   input  logic             dec_ref,
   output logic             busy,
   output logic             bad_cnt
);
   localparam int SUM_W = OUT_W + 2;
   localparam logic [SUM_W-1:0] MAX_V = SUM_W'((1 << OUT_W) - 1);

   logic [OUT_W-1:0] cnt_q;
   logic [SUM_W-1:0] up_sum;
   logic [SUM_W-1:0] dn_sum;
   logic [SUM_W-1:0] res;
   logic             under;
   logic             over;

   always_comb begin
      up_sum = {2'b00, cnt_q} + SUM_W'(inc_cmd) + SUM_W'(inc_ref);
      dn_sum = SUM_W'(dec_cmd) + SUM_W'(dec_ref);
      under  = up_sum < dn_sum;
      res    = under ? '0 : (up_sum - dn_sum);
      over   = !under && (res > MAX_V);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (over) begin
         cnt_q <= MAX_V[OUT_W-1:0];
      end else begin
         cnt_q <= res[OUT_W-1:0];
      end
   end

   assign busy    = |cnt_q;
   assign bad_cnt = under || over;

endmodule

// File: rtl/rank_pwr_entry_tmr.sv
// Counts consecutive qualifying cycles before power-down entry.
module rank_pwr_entry_tmr #(
   parameter int TH_W      = 8,
   parameter bit USE_TIMER = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            qual,
   input  logic [TH_W-1:0] thresh,
   output logic            hit
);
   generate
      if (USE_TIMER) begin : g_timer
         logic [TH_W-1:0] run_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               run_q <= '0;
            end else if (!qual || (run_q >= thresh)) begin
               run_q <= '0;
            end else begin
               run_q <= run_q + 1'b1;
            end
         end
         assign hit = qual && (run_q >= thresh);
      end else begin : g_direct
         logic unused_in;
         assign unused_in = clk ^ rst_n ^ (|thresh);
         assign hit = qual;
      end
   endgenerate

endmodule

// File: rtl/rank_pwr_wake_tmr.sv
// Holds off commands for a programmable time after a wake-up.
module rank_pwr_wake_tmr #(
   parameter int DLY_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [DLY_W-1:0] dly,
   output logic             busy
);
   logic [DLY_W-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_q <= '0;
      end else if (load) begin
         left_q <= dly;
      end else if (left_q != '0) begin
         left_q <= left_q - 1'b1;
      end
   end

   assign busy = left_q != '0;

endmodule

// File: rtl/rank_pwr_fsm.sv
// Power-state sequencing with staggered descent into self-refresh.
module rank_pwr_fsm
   import rank_pwr_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ref_start,
   input  logic       ref_done,
   input  logic       bank_open,
   input  logic       rd_any,
   input  logic       sref_force,
   input  logic       ev_busy,
   input  logic       wake_busy,
   input  logic       entry_hit,
   output pwr_state_e state,
   output logic       from_prepd,
   output logic       entry_qual,
   output logic       ref_ok,
   output logic       done_ok,
   output logic       enter_evt,
   output logic       exit_evt,
   output logic       bad_req
);
   pwr_state_e nxt;
   logic       nxt_from_prepd;
   logic       demand;

   assign demand  = rd_any || ev_busy;
   assign ref_ok  = ref_start && ((state == PS_IDLE) || (state == PS_PREPD));
   assign done_ok = ref_done && (state == PS_REF);
   assign bad_req = (ref_start && !ref_ok) || (ref_done && !done_ok);

   assign entry_qual = !wake_busy && !demand &&
                       (((state == PS_IDLE) && !bank_open && !ref_start) ||
                        ((state == PS_ACT) && bank_open));

   always_comb begin
      nxt            = state;
      nxt_from_prepd = from_prepd;
      unique case (state)
         PS_IDLE: begin
            if (ref_ok) begin
               nxt            = PS_REF;
               nxt_from_prepd = 1'b0;
            end else if (bank_open) begin
               nxt = PS_ACT;
            end else if (entry_hit) begin
               nxt = PS_PREPD;
            end
         end
         PS_ACT: begin
            if (!bank_open)     nxt = PS_IDLE;
            else if (entry_hit) nxt = PS_ACTPD;
         end
         PS_ACTPD: begin
            if (demand) nxt = PS_ACT;
         end
         PS_PREPD: begin
            if (ref_ok) begin
               nxt            = PS_REF;
               nxt_from_prepd = 1'b1;
            end else if (demand || bank_open) begin
               nxt = PS_IDLE;
            end
         end
         PS_REF: begin
            if (done_ok) nxt = from_prepd ? PS_SREF : PS_IDLE;
         end
         PS_SREF: begin
            if (sref_force) nxt = PS_IDLE;
         end
         default: nxt = PS_IDLE;
      endcase
   end

   assign enter_evt = !is_asleep(state) && is_asleep(nxt);
   assign exit_evt  = is_asleep(state) && is_awake(nxt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= PS_IDLE;
         from_prepd <= 1'b0;
      end else begin
         state      <= nxt;
         from_prepd <= nxt_from_prepd;
      end
   end

endmodule

// File: rtl/rank_pwr_ctrl.sv
// Rank power-state controller top level.
module rank_pwr_ctrl
   import rank_pwr_pkg::*;
#(
   parameter int CNT_W     = 6,
   parameter int OUT_W     = 4,
   parameter int TH_W      = 8,
   parameter int DLY_W     = 6,
   parameter bit USE_TIMER = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] rd_cnt,
   input  logic [CNT_W-1:0] wr_cnt,
   input  logic             bus_next_wr,
   input  logic             cmd_issue,
   input  logic             cmd_done,
   input  logic             bank_open,
   input  logic             ref_start,
   input  logic             ref_done,
   input  logic [TH_W-1:0]  idle_thresh,
   input  logic [DLY_W-1:0] exit_dly,
   output logic [2:0]       pwr_state,
   output logic             low_pwr,
   output logic             pd_enter,
   output logic             pd_exit,
   output logic             cmd_ready,
   output logic             err_sticky
);
   generate
      if (CNT_W < 1) begin : g_bad_cnt
         $error("CNT_W must be at least 1");
      end
      if (OUT_W < 2) begin : g_bad_out
         $error("OUT_W must be at least 2");
      end
      if (TH_W < 1) begin : g_bad_th
         $error("TH_W must be at least 1");
      end
      if (DLY_W < 1) begin : g_bad_dly
         $error("DLY_W must be at least 1");
      end
   endgenerate

   pwr_state_e state;
   logic rd_any, wr_any, sref_force;
   logic ev_busy, bad_cnt, wake_busy, entry_hit, entry_qual;
   logic from_prepd, ref_ok, done_ok, enter_evt, exit_evt, bad_req;
   logic enter_q, exit_q, err_q;

   assign rd_any     = |rd_cnt;
   assign wr_any     = |wr_cnt;
   assign sref_force = rd_any || (bus_next_wr && wr_any);

   rank_pwr_evcnt #(.OUT_W(OUT_W)) u_evcnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc_cmd (cmd_issue),
      .inc_ref (ref_ok),
      .dec_cmd (cmd_done),
      .dec_ref (done_ok),
      .busy    (ev_busy),
      .bad_cnt (bad_cnt)
   );

   rank_pwr_entry_tmr #(.TH_W(TH_W), .USE_TIMER(USE_TIMER)) u_entry (
      .clk    (clk),
      .rst_n  (rst_n),
      .qual   (entry_qual),
      .thresh (idle_thresh),
      .hit    (entry_hit)
   );

   rank_pwr_wake_tmr #(.DLY_W(DLY_W)) u_wake (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (exit_evt),
      .dly   (exit_dly),
      .busy  (wake_busy)
   );

   rank_pwr_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .ref_start  (ref_start),
      .ref_done   (ref_done),
      .bank_open  (bank_open),
      .rd_any     (rd_any),
      .sref_force (sref_force),
      .ev_busy    (ev_busy),
      .wake_busy  (wake_busy),
      .entry_hit  (entry_hit),
      .state      (state),
      .from_prepd (from_prepd),
      .entry_qual (entry_qual),
      .ref_ok     (ref_ok),
      .done_ok    (done_ok),
      .enter_evt  (enter_evt),
      .exit_evt   (exit_evt),
      .bad_req    (bad_req)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         enter_q <= 1'b0;
         exit_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         enter_q <= enter_evt;
         exit_q  <= exit_evt;
         err_q   <= err_q || bad_req || bad_cnt;
      end
   end

   assign pwr_state  = state;
   assign low_pwr    = is_asleep(state) || ((state == PS_REF) && from_prepd);
   assign pd_enter   = enter_q;
   assign pd_exit    = exit_q;
   assign cmd_ready  = is_awake(state) && !wake_busy;
   assign err_sticky = err_q;

endmodule

// File: rtl/rank_pwr_ctrl_chk.sv
// Port-level properties, attached to the top through bind.
module rank_pwr_ctrl_chk #(
   parameter int CNT_W = 6,
   parameter int DLY_W = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CNT_W-1:0] rd_cnt,
   input logic             ref_done,
   input logic [DLY_W-1:0] exit_dly,
   input logic [2:0]       pwr_state,
   input logic             low_pwr,
   input logic             pd_enter,
   input logic             pd_exit,
   input logic             cmd_ready,
   input logic             err_sticky
);
   p_state_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_state <= 3'd5);

   p_actpd_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state == 3'd5) |=> (pwr_state == 3'd5) || (pwr_state == 3'd4));

   p_sref_from_ref_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state == 3'd1) && ref_done && low_pwr |=> pwr_state == 3'd2);

   p_sref_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state == 3'd2) |=> (pwr_state == 3'd2) || (pwr_state == 3'd0));

   p_entry_no_reads_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pd_enter && (pwr_state != 3'd2) |-> $past(rd_cnt) == '0);

   p_wake_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      pd_exit && ($past(exit_dly) != '0) |-> !cmd_ready);

   p_asleep_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state == 3'd2) || (pwr_state == 3'd3) || (pwr_state == 3'd5)
      |-> low_pwr && !cmd_ready);

   p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(pd_enter && pd_exit));

   p_err_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
      err_sticky |=> err_sticky);

endmodule

bind rank_pwr_ctrl rank_pwr_ctrl_chk #(.CNT_W(CNT_W), .DLY_W(DLY_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rd_cnt     (rd_cnt),
   .ref_done   (ref_done),
   .exit_dly   (exit_dly),
   .pwr_state  (pwr_state),
   .low_pwr    (low_pwr),
   .pd_enter   (pd_enter),
   .pd_exit    (pd_exit),
   .cmd_ready  (cmd_ready),
   .err_sticky (err_sticky)
);

// File: tb/rank_pwr_ctrl_tb_top.sv
`timescale 1ns/1ps
module rank_pwr_ctrl_tb_top;
   localparam int CNT_W = 6;
   localparam int OUT_W = 4;
   localparam int TH_W  = 8;
   localparam int DLY_W = 6;
   localparam int OMAX  = (1 << OUT_W) - 1;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [CNT_W-1:0] rd_cnt = '0;
   logic [CNT_W-1:0] wr_cnt = '0;
   logic             bus_next_wr = 1'b0;
   logic             cmd_issue = 1'b0;
   logic             cmd_done = 1'b0;
   logic             bank_open = 1'b0;
   logic             ref_start = 1'b0;
   logic             ref_done = 1'b0;
   logic [TH_W-1:0]  idle_thresh = '0;
   logic [DLY_W-1:0] exit_dly = '0;
   logic [2:0]       pwr_state;
   logic             low_pwr, pd_enter, pd_exit, cmd_ready, err_sticky;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   rank_pwr_ctrl #(.CNT_W(CNT_W), .OUT_W(OUT_W), .TH_W(TH_W), .DLY_W(DLY_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .rd_cnt(rd_cnt), .wr_cnt(wr_cnt),
      .bus_next_wr(bus_next_wr), .cmd_issue(cmd_issue), .cmd_done(cmd_done),
      .bank_open(bank_open), .ref_start(ref_start), .ref_done(ref_done),
      .idle_thresh(idle_thresh), .exit_dly(exit_dly), .pwr_state(pwr_state),
      .low_pwr(low_pwr), .pd_enter(pd_enter), .pd_exit(pd_exit),
      .cmd_ready(cmd_ready), .err_sticky(err_sticky));

   // reference model state, built from the requirements
   int m_st, m_out, m_run, m_wake;
   bit m_pre, m_ent, m_ext, m_err;
   int n_st, n_out, n_run, n_wake;
   bit n_pre, n_ent, n_ext, n_err;

   function automatic bit asleep(input int s);
      return (s == 2) || (s == 3) || (s == 5);
   endfunction

   function automatic bit awake(input int s);
      return (s == 0) || (s == 4);
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      m_st = 0; m_out = 0; m_run = 0; m_wake = 0;
      m_pre = 0; m_ent = 0; m_ext = 0; m_err = 0;
   endtask

   task automatic model_next();
      bit rd_any, demand, qual, hit, rok, dok, force_x;
      int up, dn;
      rd_any  = rd_cnt != 0;
      demand  = rd_any || (m_out != 0);
      force_x = rd_any || (bus_next_wr && wr_cnt != 0);
      rok     = ref_start && (m_st == 0 || m_st == 3);
      dok     = ref_done && (m_st == 1);
      qual    = (m_wake == 0) && !demand &&
                ((m_st == 0 && !bank_open && !ref_start) || (m_st == 4 && bank_open));
      hit     = qual && (m_run >= int'(idle_thresh));
      n_run   = (!qual || hit) ? 0 : m_run + 1;
      n_st = m_st; n_pre = m_pre;
      case (m_st)
         0: if (rok) begin n_st = 1; n_pre = 0; end
            else if (bank_open) n_st = 4;
            else if (hit) n_st = 3;
         4: if (!bank_open) n_st = 0; else if (hit) n_st = 5;
         5: if (demand) n_st = 4;
         3: if (rok) begin n_st = 1; n_pre = 1; end
            else if (demand || bank_open) n_st = 0;
         1: if (dok) n_st = m_pre ? 2 : 0;
         2: if (force_x) n_st = 0;
         default: n_st = 0;
      endcase
      n_ent = !asleep(m_st) && asleep(n_st);
      n_ext = asleep(m_st) && awake(n_st);
      n_wake = n_ext ? int'(exit_dly) : (m_wake > 0 ? m_wake - 1 : 0);
      up = m_out + int'(cmd_issue) + int'(rok);
      dn = int'(cmd_done) + int'(dok);
      n_err = m_err || (ref_start && !rok) || (ref_done && !dok);
      if (up < dn) begin n_out = 0; n_err = 1; end
      else if (up - dn > OMAX) begin n_out = OMAX; n_err = 1; end
      else n_out = up - dn;
   endtask

   task automatic compare_all();
      bit e_low, e_rdy;
      e_low = asleep(m_st) || (m_st == 1 && m_pre);
      e_rdy = awake(m_st) && (m_wake == 0);
      chk(int'(pwr_state) == m_st, "R2 state", int'(pwr_state), m_st);
      chk(low_pwr == e_low, "R10 low_pwr", int'(low_pwr), int'(e_low));
      chk(pd_enter == m_ent, "R11 pd_enter", int'(pd_enter), int'(m_ent));
      chk(pd_exit == m_ext, "R11 pd_exit", int'(pd_exit), int'(m_ext));
      chk(cmd_ready == e_rdy, "R9 cmd_ready", int'(cmd_ready), int'(e_rdy));
      chk(err_sticky == m_err, "R12 err_sticky", int'(err_sticky), int'(m_err));
   endtask

   task automatic cyc();
      model_next();
      @(posedge clk);
      m_st = n_st; m_pre = n_pre; m_out = n_out; m_run = n_run;
      m_wake = n_wake; m_ent = n_ent; m_ext = n_ext; m_err = n_err;
      @(negedge clk);
      compare_all();
   endtask

   task automatic clear_in();
      rd_cnt = '0; wr_cnt = '0; bus_next_wr = 0; cmd_issue = 0; cmd_done = 0;
      bank_open = 0; ref_start = 0; ref_done = 0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 0;
      clear_in();
      model_reset();
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      compare_all();
   endtask

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      idle_thresh = 8'd3;
      exit_dly    = 6'd2;
      do_reset();
      // R1: reset values and codes
      chk(pwr_state == 3'd0, "R1 reset state", int'(pwr_state), 0);
      chk(cmd_ready == 1'b1, "R1 reset ready", int'(cmd_ready), 1);
      chk(!low_pwr && !pd_enter && !pd_exit && !err_sticky, "R1 reset flags",
          int'({low_pwr, pd_enter, pd_exit, err_sticky}), 0);

      // R7: idle entry after thresh+1 qualifying cycles
      repeat (3) cyc();
      chk(pwr_state == 3'd0, "R7 still idle", int'(pwr_state), 0);
      cyc();
      chk(pwr_state == 3'd3, "R7 precharge power-down", int'(pwr_state), 3);
      chk(pd_enter == 1'b1, "R11 enter strobe", int'(pd_enter), 1);

      // R4 / R10: refresh from precharge power-down
      ref_start = 1; cyc(); ref_start = 0;
      chk(pwr_state == 3'd1, "R4 to refresh", int'(pwr_state), 1);
      chk(low_pwr == 1'b1, "R10 refresh toward self-refresh", int'(low_pwr), 1);
      cyc();
      ref_done = 1; cyc(); ref_done = 0;
      chk(pwr_state == 3'd2, "R5 self-refresh", int'(pwr_state), 2);

      // R6: writes with read direction do not wake
      wr_cnt = 6'd2; bus_next_wr = 0;
      repeat (2) cyc();
      chk(pwr_state == 3'd2, "R6 writes, read direction", int'(pwr_state), 2);
      bus_next_wr = 1; cyc();
      chk(pwr_state == 3'd0, "R6 writes, write direction", int'(pwr_state), 0);
      chk(pd_exit == 1'b1 && cmd_ready == 1'b0, "R9 exit holds ready",
          int'({pd_exit, cmd_ready}), 2);
      wr_cnt = '0; bus_next_wr = 0;
      cyc();
      chk(cmd_ready == 1'b0, "R9 delay running", int'(cmd_ready), 0);
      cyc();
      chk(cmd_ready == 1'b1, "R9 delay expired", int'(cmd_ready), 1);

      // R2 / R8: active, outstanding command blocks entry
      bank_open = 1; cyc();
      chk(pwr_state == 3'd4, "R2 to active", int'(pwr_state), 4);
      cmd_issue = 1; cyc(); cmd_issue = 0;
      repeat (6) cyc();
      chk(pwr_state == 3'd4, "R8 outstanding blocks entry", int'(pwr_state), 4);
      cmd_done = 1; cyc(); cmd_done = 0;
      repeat (3) cyc();
      chk(pwr_state == 3'd4, "R8 counting after drain", int'(pwr_state), 4);
      cyc();
      chk(pwr_state == 3'd5, "R7 active power-down", int'(pwr_state), 5);

      // R3: demand wakes active power-down to active
      rd_cnt = 6'd1; cyc(); rd_cnt = '0;
      chk(pwr_state == 3'd4 && pd_exit, "R3 wake to active", int'(pwr_state), 4);
      bank_open = 0; cyc();
      chk(pwr_state == 3'd0, "R3 active to idle", int'(pwr_state), 0);

      // R12: refresh start while active is ignored
      bank_open = 1; cyc();
      ref_start = 1; cyc(); ref_start = 0;
      chk(pwr_state == 3'd4, "R12 ignored request", int'(pwr_state), 4);
      chk(err_sticky == 1'b1, "R12 error set", int'(err_sticky), 1);
      repeat (3) cyc();
      chk(err_sticky == 1'b1, "R12 error sticky", int'(err_sticky), 1);

      // biased random blocks, model compared every cycle
      for (int blk = 0; blk < 12; blk++) begin
         do_reset();
         idle_thresh = TH_W'($urandom % 5);
         exit_dly    = DLY_W'($urandom % 4);
         for (int i = 0; i < 400; i++) begin
            rd_cnt      = ($urandom % 6 == 0) ? CNT_W'($urandom % 3) : '0;
            wr_cnt      = ($urandom % 4 == 0) ? CNT_W'($urandom % 3) : '0;
            bus_next_wr = ($urandom % 2) == 1;
            if ($urandom % 10 == 0) bank_open = !bank_open;
            cmd_issue   = ($urandom % 8) == 0;
            cmd_done    = (m_out > 0) ? (($urandom % 5) == 0) : (($urandom % 60) == 0);
            ref_start   = ($urandom % 25) == 0;
            ref_done    = (m_st == 1) ? (($urandom % 3) == 0) : (($urandom % 150) == 0);
            cyc();
         end
      end

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule